// File: doc/BRIEF.md
# Serial DAC Command Receiver

This block is the digital front end of a single-channel voltage-output converter. It listens on a three-wire serial port made of a frame-select line (active low), a serial clock and a serial data line. All three pins are brought into a faster system clock through two-flop synchronisers. Falling edges of the serial clock are then detected as single-cycle events in that clock domain.

A frame is armed by a falling edge on the frame-select line. The receiver then shifts the data line in, most significant bit first, on each falling serial-clock edge. On the sixteenth edge it commits the frame at once, without waiting for frame-select to rise. The commit loads a 10-bit straight-binary output code and a 2-bit output-state selection. The selection is presented decoded as a one-hot word, and a single-cycle strobe marks the commit. Once a frame has committed, the receiver ignores the serial clock until frame-select has gone high and then low again. A frame cut short by frame-select rising is dropped.

The analogue parts (the resistor ladder, the buffer and the output-state switches) lie outside this block. The block produces only their digital control words.

Top module: `serdac_in_port`

## Requirements
- R1: After reset, the code output is 0, the state output is 4'b0001 (normal drive) and the strobe is low.
- R2: Only a falling edge of the frame-select line starts a frame. Serial-clock edges while frame-select is high change no output and give no strobe.
- R3: Serial data is captured on falling serial-clock edges, first bit into word bit 15. In the 16-bit word, bits 15:14 and 1:0 are ignored, bits 13:12 are the state field and bits 11:2 are the code, with bit 11 the most significant.
- R4: The code output takes the 10-bit code field as a straight binary value from 0 to 1023.
- R5: The state output is one-hot. Field 00 sets bit 0 (normal drive), 01 sets bit 1 (grounded through 1k), 10 sets bit 2 (grounded through 100k) and 11 sets bit 3 (high impedance).
- R6: A frame commits on its sixteenth falling serial-clock edge while frame-select is still low. The outputs take their new values within 8 system clocks of that edge.
- R7: After a commit, further serial-clock edges while frame-select stays low change nothing. A new frame needs frame-select to rise and then fall.
- R8: If frame-select rises before the sixteenth edge, the partial frame is dropped. Neither output changes and no strobe is given.
- R9: The strobe is high for exactly one system clock per committed frame. The code output changes only in a cycle where the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least four times the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_ni | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| din_i | input | 1 | Serial data, asynchronous |
| dac_code_o | output | 10 | Committed output code |
| pd_state_o | output | 4 | One-hot output state: normal, 1k to ground, 100k to ground, high impedance |
| upd_o | output | 1 | One-cycle commit strobe |

## Verification
Every one of the 1024 codes is sent once. The state field and the padding bits are derived from the code, so all four states occur and the padding bits take every value. This separates a misplaced field or a wrong shift direction from a correct one. Odd-numbered frames are followed by extra serial-clock pulses with frame-select still low, which separates a receiver that disarms on commit from one that keeps shifting. Separate runs send serial clocks with frame-select high, and frames cut off after 1 and after 15 bits. These show whether a frame starts only on a select edge and whether an incomplete word is really thrown away rather than committed early.

// File: rtl/serdac_pkg.sv
`timescale 1ns/1ps
package serdac_pkg;
  localparam int FRAME_W  = 16;
  localparam int CODE_W   = 10;
  localparam int PD_W     = 2;
  localparam int CODE_LSB = 2;
  localparam int PD_LSB   = 12;
  localparam int SYNC_STG = 2;

  typedef enum logic [PD_W-1:0] {
    PD_NORMAL   = 2'b00,
    PD_GND_1K   = 2'b01,
    PD_GND_100K = 2'b10,
    PD_HIZ      = 2'b11
  } pd_sel_e;
endpackage

// File: rtl/sdi_sync.sv
`timescale 1ns/1ps
module sdi_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_in;
    if (s == 0) begin : g_first
      assign stg_in = d_i;
    end else begin : g_next
      assign stg_in = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[s] <= RST_VAL;
      end else begin
        stg_q[s] <= stg_in;
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sdi_edge.sv
`timescale 1ns/1ps
module sdi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic sync_s_i,
  output logic sclk_fall_o,
  output logic sync_fall_o,
  output logic sync_rise_o
);
  logic sclk_prev_q, sync_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b1;
      sync_prev_q <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s_i;
      sync_prev_q <= sync_s_i;
    end
  end

  always_comb begin
    sclk_fall_o = sclk_prev_q  & ~sclk_s_i;
    sync_fall_o = sync_prev_q  & ~sync_s_i;
    sync_rise_o = ~sync_prev_q &  sync_s_i;
  end

  // a falling edge needs the level to rise again before the next one
  AST_SCLK_FALL_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_fall_o |=> !sclk_fall_o); // R3
endmodule

// File: rtl/sdi_frame.sv
`timescale 1ns/1ps
module sdi_frame #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_s_i,
  input  logic               din_s_i,
  input  logic               sclk_fall_i,
  input  logic               sync_fall_i,
  input  logic               sync_rise_i,
  output logic               done_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  logic               active_q, active_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic [FRAME_W-1:0] shreg_q, shreg_n;
  logic               done_q, done_n;
  logic               shift_en;

  assign shift_en = active_q & ~sync_s_i & sclk_fall_i & ~sync_fall_i;

  always_comb begin
    active_n = active_q;
    cnt_n    = cnt_q;
    shreg_n  = shreg_q;
    done_n   = 1'b0;
    if (sync_fall_i) begin
      active_n = 1'b1;
      cnt_n    = '0;
    end else if (sync_s_i) begin
      active_n = 1'b0;
    end else if (shift_en) begin
      shreg_n = {shreg_q[FRAME_W-2:0], din_s_i};
      if (cnt_q == LAST_BIT) begin
        active_n = 1'b0;
        done_n   = 1'b1;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shreg_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
      shreg_q  <= shreg_n;
      done_q   <= done_n;
    end
  end

  assign done_o = done_q;
  assign word_o = shreg_q;

  AST_ARM_ON_SYNC_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_fall_i |=> (active_q && cnt_q == '0)); // R2
  AST_DONE_FROM_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(active_q)); // R6
  AST_DISARM_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !active_q); // R7
  AST_RISE_DROPS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_rise_i |=> (!active_q && !done_q)); // R8
endmodule

// File: rtl/sdi_regs.sv
`timescale 1ns/1ps
module sdi_regs #(
  parameter int FRAME_W  = 16,
  parameter int CODE_W   = 10,
  parameter int PD_W     = 2,
  parameter int CODE_LSB = 2,
  parameter int PD_LSB   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               done_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [(1<<PD_W)-1:0] state_o,
  output logic               upd_o
);
  localparam int STATE_N = 1 << PD_W;

  logic [CODE_W-1:0]  code_q, code_n;
  logic [STATE_N-1:0] state_q, state_n, state_dec;
  logic [PD_W-1:0]    pd_field;
  logic               upd_q;
  logic               load_en;
  logic               pad_unused;

  assign load_en    = done_i;
  assign pd_field   = word_i[PD_LSB +: PD_W];
  assign pad_unused = ^{word_i[FRAME_W-1:PD_LSB+PD_W], word_i[CODE_LSB-1:0]};

  for (genvar m = 0; m < STATE_N; m++) begin : g_dec
    assign state_dec[m] = (pd_field == PD_W'(m));
  end

  always_comb begin
    code_n  = code_q;
    state_n = state_q;
    if (load_en) begin
      code_n  = word_i[CODE_LSB +: CODE_W];
      state_n = state_dec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      state_q <= STATE_N'(1);
      upd_q   <= 1'b0;
    end else begin
      code_q  <= code_n;
      state_q <= state_n;
      upd_q   <= load_en;
    end
  end

  assign code_o  = code_q;
  assign state_o = state_q;
  assign upd_o   = upd_q;

  AST_STATE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1); // R5
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |=> !upd_q); // R9
  AST_CODE_HOLDS_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |-> $stable(code_q)); // R9
  AST_STATE_HOLDS_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_q |-> $stable(state_q)); // R8
endmodule

// File: rtl/serdac_in_port.sv
`timescale 1ns/1ps
module serdac_in_port
  import serdac_pkg::*;
#(
  parameter int P_FRAME_W  = FRAME_W,
  parameter int P_CODE_W   = CODE_W,
  parameter int P_PD_W     = PD_W,
  parameter int P_CODE_LSB = CODE_LSB,
  parameter int P_PD_LSB   = PD_LSB,
  parameter int P_SYNC_STG = SYNC_STG
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sync_ni,
  input  logic                     sclk_i,
  input  logic                     din_i,
  output logic [P_CODE_W-1:0]      dac_code_o,
  output logic [(1<<P_PD_W)-1:0]   pd_state_o,
  output logic                     upd_o
);
  localparam int PIN_W = 3;
  localparam int B_DIN = 0, B_SCLK = 1, B_SYNC = 2;

  logic                 rst_sync_n;
  logic [PIN_W-1:0]     pins_raw, pins_s;
  logic                 sclk_fall, sync_fall, sync_rise;
  logic                 frame_done;
  logic [P_FRAME_W-1:0] frame_word;

  sdi_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (rst_sync_n)
  );

  always_comb begin
    pins_raw         = '0;
    pins_raw[B_DIN]  = din_i;
    pins_raw[B_SCLK] = sclk_i;
    pins_raw[B_SYNC] = sync_ni;
  end

  sdi_sync #(.WIDTH(PIN_W), .STAGES(P_SYNC_STG), .RST_VAL(3'b110)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  sdi_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .sclk_s_i    (pins_s[B_SCLK]),
    .sync_s_i    (pins_s[B_SYNC]),
    .sclk_fall_o (sclk_fall),
    .sync_fall_o (sync_fall),
    .sync_rise_o (sync_rise)
  );

  sdi_frame #(.FRAME_W(P_FRAME_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .sync_s_i    (pins_s[B_SYNC]),
    .din_s_i     (pins_s[B_DIN]),
    .sclk_fall_i (sclk_fall),
    .sync_fall_i (sync_fall),
    .sync_rise_i (sync_rise),
    .done_o      (frame_done),
    .word_o      (frame_word)
  );

  sdi_regs #(
    .FRAME_W  (P_FRAME_W),
    .CODE_W   (P_CODE_W),
    .PD_W     (P_PD_W),
    .CODE_LSB (P_CODE_LSB),
    .PD_LSB   (P_PD_LSB)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .done_i  (frame_done),
    .word_i  (frame_word),
    .code_o  (dac_code_o),
    .state_o (pd_state_o),
    .upd_o   (upd_o)
  );

  AST_STROBE_FOLLOWS_DONE: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    frame_done |=> upd_o); // R6
endmodule

// File: tb/serdac_in_port_tb.sv
`timescale 1ns/1ps
module serdac_in_port_tb;
  localparam int HALF = 10; // serial clock half period, ns

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n = 1'b1;
  logic       sclk = 1'b1;
  logic       din = 1'b0;
  logic [9:0] code;
  logic [3:0] state;
  logic       upd;

  int n_chk = 0;
  int n_fail = 0;
  int n_strobe = 0;
  int n_wide = 0;
  logic upd_prev = 1'b0;

  always #2 clk = ~clk;

  serdac_in_port u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sync_ni    (sync_n),
    .sclk_i     (sclk),
    .din_i      (din),
    .dac_code_o (code),
    .pd_state_o (state),
    .upd_o      (upd)
  );

  always @(negedge clk) begin
    if (upd) n_strobe++;
    if (upd && upd_prev) n_wide++;
    upd_prev <= upd;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_bit(input logic b);
    din = b;
    #HALF sclk = 1'b0;
    #HALF sclk = 1'b1;
  endtask

  task automatic send_bits(input logic [15:0] w, input int nbits);
    sync_n = 1'b1;
    #(2*HALF);
    sync_n = 1'b0;
    #(2*HALF);
    for (int i = 0; i < nbits; i++) pulse_bit(w[15-i]);
    #40;
  endtask

  task automatic settle;
    @(negedge clk);
  endtask

  initial begin : wdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [9:0]  d;
    logic [1:0]  pd;
    logic [15:0] w;
    int          s0;
    logic [9:0]  last_code;
    logic [3:0]  last_state;

    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    settle();
    chk(code == 10'd0, "R1 code", int'(code), 0);
    chk(state == 4'b0001, "R1 state", int'(state), 1);
    chk(upd == 1'b0 && n_strobe == 0, "R1 strobe", n_strobe, 0);

    // R2: clocks with select high do nothing
    sync_n = 1'b1;
    for (int i = 0; i < 20; i++) pulse_bit(1'b1);
    #40; settle();
    chk(code == 10'd0, "R2 code", int'(code), 0);
    chk(state == 4'b0001, "R2 state", int'(state), 1);
    chk(n_strobe == 0, "R2 strobe", n_strobe, 0);

    // R3 R4 R5 R6 R9: every code
    for (int k = 0; k < 1024; k++) begin
      d  = 10'(k);
      pd = d[1:0] ^ d[9:8];
      w  = {d[3:2], pd, d, d[5:4]};
      s0 = n_strobe;
      send_bits(w, 16);
      settle();
      chk(code == d, "R4 code", int'(code), int'(d));
      chk(state == (4'b0001 << pd), "R5 state", int'(state), int'(4'b0001 << pd));
      chk(n_strobe == s0 + 1, "R6 strobe", n_strobe, s0 + 1);
      if (k % 2 == 1) begin
        // R7: more clocks while select stays low
        for (int j = 0; j < 3; j++) pulse_bit(~din);
        #40; settle();
        chk(code == d, "R7 code", int'(code), int'(d));
        chk(n_strobe == s0 + 1, "R7 strobe", n_strobe, s0 + 1);
      end
    end
    chk(n_wide == 0, "R9 width", n_wide, 0);
    chk(n_strobe == 1024, "R9 count", n_strobe, 1024);

    // R8: truncated frames are dropped
    last_code  = code;
    last_state = state;
    s0 = n_strobe;
    send_bits(16'h2A5C, 15);
    sync_n = 1'b1; #40; settle();
    chk(code == last_code, "R8 code 15b", int'(code), int'(last_code));
    chk(state == last_state, "R8 state 15b", int'(state), int'(last_state));
    send_bits(16'hFFFF, 1);
    sync_n = 1'b1; #40; settle();
    chk(code == last_code, "R8 code 1b", int'(code), int'(last_code));
    chk(n_strobe == s0, "R8 strobe", n_strobe, s0);

    // R3: full frame after a truncated one, padding set
    send_bits(16'b11_10_0000000001_11, 16);
    settle();
    chk(code == 10'd1, "R3 code lsb", int'(code), 1);
    chk(state == 4'b0100, "R3 state", int'(state), 4);
    chk(n_wide == 0, "R9 width end", n_wide, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule